// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block turns a digital low-supply indication and a watchdog fault request into a processor reset of controlled width. While the external comparator reports a low supply, or while the system runs from its backup battery, reset is held asserted. Once both conditions clear, reset stays asserted for a fixed number of timebase ticks before it lets go, so the processor clock has time to settle. A watchdog request arriving while the processor is running produces one reset pulse of the same width, timed by the same stretch counter.

The same block protects battery-backed memory: each memory chip-enable passes through only while the supply is good, and is forced inactive the moment a low supply or battery operation is reported. A one-cycle strobe marks the end of every reset so that a watchdog can restart its timing. The tick is a clock enable from a shared timebase; the hold width is a parameter, 512 ticks by default (about 50 ms at a 10.24 kHz tick).

Top module: `rstpulse_gen`

## Requirements
- R1: `rst_n_out` is 0 in the clock cycle after `low_line` or `batt_mode` is sampled at 1 and stays 0 for as long as either one is 1.
- R2: With `low_line` and `batt_mode` both 0, reset releases (`rst_n_out` = 1) in the cycle after the HOLD_TICKS-th clock edge with `tick_en` = 1, counted from the first edge after both were seen at 0; edges without `tick_en` do not count.
- R3: A `wd_expire` pulse sampled while `rst_n_out` = 1 and no supply fault is present makes `rst_n_out` 0 in the next cycle, for a pulse of HOLD_TICKS ticks.
- R4: `rst_out` is always the inverse of `rst_n_out`.
- R5: Each bit of `ce_out_n` (active low) equals the same bit of `ce_in_n` while `low_line` and `batt_mode` are both 0, and is 1 in the same cycle, without a clock edge, while either is 1.
- R6: If `low_line` reasserts during the hold, reset stays asserted and the next recovery again needs the full HOLD_TICKS ticks.
- R7: `rst_done` is 1 for exactly one cycle, the first cycle with `rst_n_out` = 1 after a reset; it is 0 at all other times.
- R8: A `wd_expire` pulse sampled while reset is asserted is ignored and does not lengthen the pulse.
- R9: While `srst` = 1, `rst_n_out` is 0 from the next cycle and the tick count is cleared, so release after `srst` needs the full HOLD_TICKS ticks.
- R10: A supply fault sampled on the same edge as the final hold tick wins: reset is not released and `rst_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous system reset, active high |
| tick_en | input | 1 | Timebase tick, one-cycle clock enable |
| low_line | input | 1 | Low-supply indication from an external comparator, active high |
| batt_mode | input | 1 | Supply is below the backup battery, active high |
| wd_expire | input | 1 | Watchdog timeout request, one-cycle pulse |
| ce_in_n | input | NUM_CE | Memory chip-enables from the processor, active low |
| rst_n_out | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| ce_out_n | output | NUM_CE | Gated memory chip-enables, active low |
| rst_done | output | 1 | One-cycle strobe at the end of each reset |

## Verification
Two functions meet on the edge that carries the final hold tick: the release itself and either a new supply fault or a watchdog request. The bench raises `low_line` together with that last tick and expects reset to stay low with no strobe, then later raises `wd_expire` together with the last tick of another hold and expects the release and strobe to happen normally with reset remaining high afterwards. A third overlap, `low_line` rising while the chip-enable input is active, is judged the same cycle, before any edge, on `ce_out_n`.

// File: rtl/rstpulse_pkg.sv
package rstpulse_pkg;

  // Reset sequencer states. RUN is the only state with reset released.
  typedef enum logic [1:0] {
    ST_FORCED  = 2'd0,  // supply fault present, reset held
    ST_STRETCH = 2'd1,  // fault gone, counting hold ticks
    ST_RUN     = 2'd2   // reset released
  } rp_state_e;

  function automatic int unsigned rp_cnt_width(input int unsigned ticks);
    return (ticks < 2) ? 1 : $clog2(ticks);
  endfunction

endpackage

// File: rtl/rp_stretch_cnt.sv
module rp_stretch_cnt #(
  parameter int unsigned HOLD_TICKS = 512
) (
  input  logic clk,
  input  logic clear,
  input  logic run,
  input  logic tick_en,
  output logic last
);
  localparam int unsigned CNT_W = rstpulse_pkg::rp_cnt_width(HOLD_TICKS);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt_q <= '0;
    end else if (run && tick_en) begin
      cnt_q <= (cnt_q == LAST_VAL) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last = run && tick_en && (cnt_q == LAST_VAL);

endmodule

// File: rtl/rp_seq.sv
module rp_seq
  import rstpulse_pkg::*;
(
  input  logic clk,
  input  logic srst,
  input  logic fault,
  input  logic wd_expire,
  input  logic hold_last,
  output logic cnt_clear,
  output logic cnt_run,
  output logic rel,
  output logic done
);
  rp_state_e state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d = state_q;
    if (fault) begin
      state_d = ST_FORCED;
    end else begin
      unique case (state_q)
        ST_FORCED:  state_d = ST_STRETCH;
        ST_STRETCH: state_d = hold_last ? ST_RUN : ST_STRETCH;
        ST_RUN:     state_d = wd_expire ? ST_STRETCH : ST_RUN;
        default:    state_d = ST_FORCED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      state_q <= ST_STRETCH;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign cnt_clear = srst || fault || (state_q != ST_STRETCH);
  assign cnt_run   = (state_q == ST_STRETCH) && !fault;
  assign rel       = (state_q == ST_RUN);
  assign done      = done_q;

endmodule

// File: rtl/rp_ce_gate.sv
module rp_ce_gate #(
  parameter int unsigned NUM_CE = 2
) (
  input  logic              block,
  input  logic [NUM_CE-1:0] ce_in_n,
  output logic [NUM_CE-1:0] ce_out_n
);
  for (genvar g = 0; g < NUM_CE; g++) begin : g_lane
    assign ce_out_n[g] = ce_in_n[g] | block;
  end
endmodule

// File: rtl/rstpulse_gen.sv
module rstpulse_gen #(
  parameter int unsigned HOLD_TICKS = 512,
  parameter int unsigned NUM_CE     = 2
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              tick_en,
  input  logic              low_line,
  input  logic              batt_mode,
  input  logic              wd_expire,
  input  logic [NUM_CE-1:0] ce_in_n,
  output logic              rst_n_out,
  output logic              rst_out,
  output logic [NUM_CE-1:0] ce_out_n,
  output logic              rst_done
);
  logic fault;
  logic cnt_clear;
  logic cnt_run;
  logic hold_last;
  logic rel;

  assign fault = low_line | batt_mode;

  rp_stretch_cnt #(.HOLD_TICKS(HOLD_TICKS)) u_cnt (
    .clk     (clk),
    .clear   (cnt_clear),
    .run     (cnt_run),
    .tick_en (tick_en),
    .last    (hold_last)
  );

  rp_seq u_seq (
    .clk       (clk),
    .srst      (srst),
    .fault     (fault),
    .wd_expire (wd_expire),
    .hold_last (hold_last),
    .cnt_clear (cnt_clear),
    .cnt_run   (cnt_run),
    .rel       (rel),
    .done      (rst_done)
  );

  rp_ce_gate #(.NUM_CE(NUM_CE)) u_ce (
    .block    (fault),
    .ce_in_n  (ce_in_n),
    .ce_out_n (ce_out_n)
  );

  assign rst_n_out = rel;
  assign rst_out   = ~rel;

endmodule

// File: rtl/rstpulse_gen_chk.sv
module rstpulse_gen_chk #(
  parameter int unsigned NUM_CE = 2
) (
  input logic              clk,
  input logic              srst,
  input logic              tick_en,
  input logic              low_line,
  input logic              batt_mode,
  input logic              wd_expire,
  input logic [NUM_CE-1:0] ce_in_n,
  input logic              rst_n_out,
  input logic              rst_out,
  input logic [NUM_CE-1:0] ce_out_n,
  input logic              rst_done
);
  p_fault_holds_r1: assert property (@(posedge clk) disable iff (srst)
    (low_line || batt_mode) |=> !rst_n_out);

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (srst)
    $rose(rst_n_out) |-> $past(tick_en));

  p_wd_pulse_r3: assert property (@(posedge clk) disable iff (srst)
    (wd_expire && rst_n_out && !low_line && !batt_mode) |=> !rst_n_out);

  p_inverse_r4: assert property (@(posedge clk)
    rst_out == !rst_n_out);

  p_ce_blocked_r5: assert property (@(posedge clk)
    (low_line || batt_mode) |-> (ce_out_n == {NUM_CE{1'b1}}));

  p_ce_follow_r5: assert property (@(posedge clk)
    (!low_line && !batt_mode) |-> (ce_out_n == ce_in_n));

  p_done_on_rise_r7: assert property (@(posedge clk) disable iff (srst)
    $rose(rst_n_out) |-> rst_done);

  p_done_single_r7: assert property (@(posedge clk) disable iff (srst)
    rst_done |=> !rst_done);

  p_srst_asserts_r9: assert property (@(posedge clk)
    srst |=> !rst_n_out);

  p_fault_beats_release_r10: assert property (@(posedge clk) disable iff (srst)
    (low_line || batt_mode) |=> !rst_done);
endmodule

bind rstpulse_gen rstpulse_gen_chk #(.NUM_CE(NUM_CE)) u_chk (
  .clk       (clk),
  .srst      (srst),
  .tick_en   (tick_en),
  .low_line  (low_line),
  .batt_mode (batt_mode),
  .wd_expire (wd_expire),
  .ce_in_n   (ce_in_n),
  .rst_n_out (rst_n_out),
  .rst_out   (rst_out),
  .ce_out_n  (ce_out_n),
  .rst_done  (rst_done)
);

// File: tb/rstpulse_gen_test.sv
`timescale 1ns/1ps
module rstpulse_gen_test;
  localparam int HOLD = 512;
  localparam int NCE  = 2;

  logic           clk = 1'b0;
  logic           srst = 1'b1;
  logic           tick_en = 1'b0;
  logic           low_line = 1'b0;
  logic           batt_mode = 1'b0;
  logic           wd_expire = 1'b0;
  logic [NCE-1:0] ce_in_n = '1;
  logic           rst_n_out, rst_out, rst_done;
  logic [NCE-1:0] ce_out_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rstpulse_gen #(.HOLD_TICKS(HOLD), .NUM_CE(NCE)) uut (
    .clk(clk), .srst(srst), .tick_en(tick_en), .low_line(low_line),
    .batt_mode(batt_mode), .wd_expire(wd_expire), .ce_in_n(ce_in_n),
    .rst_n_out(rst_n_out), .rst_out(rst_out), .ce_out_n(ce_out_n),
    .rst_done(rst_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reset outputs: R4 inverse is checked on every call.
  task automatic chk_rst(input string req, input bit exp_rel, input bit exp_done);
    chk(req, rst_n_out, exp_rel);
    chk({req, " R4"}, rst_out, !exp_rel);
    chk({req, " R7"}, rst_done, exp_done);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic final_tick(input bit with_wd);
    tick_en   = 1'b1;
    wd_expire = with_wd;
    @(negedge clk);
    tick_en   = 1'b0;
    wd_expire = 1'b0;
  endtask

  task automatic t_power_on;  // R9 R2 R7
    chk_rst("R9 reset state", 1'b0, 1'b0);
    srst = 1'b0;
    ticks(HOLD - 1);
    repeat (20) @(negedge clk);
    chk_rst("R2 idle cycles not counted", 1'b0, 1'b0);
    final_tick(1'b0);
    chk_rst("R2 release after hold", 1'b1, 1'b1);
    @(negedge clk);
    chk_rst("R7 strobe single cycle", 1'b1, 1'b0);
  endtask

  task automatic t_low_line;  // R1 R5 R6 R2
    ce_in_n = 2'b10;
    #1 chk("R5 ce follows", ce_out_n, 2'b10);
    low_line = 1'b1;
    #1 chk("R5 ce forced by low_line", ce_out_n, 2'b11);
    @(negedge clk);
    chk_rst("R1 low_line asserts reset", 1'b0, 1'b0);
    ticks(HOLD + 5);
    chk_rst("R1 held while low_line", 1'b0, 1'b0);
    low_line = 1'b0;
    #1 chk("R5 ce follows again", ce_out_n, 2'b10);
    @(negedge clk);
    ticks(300);
    low_line = 1'b1;
    @(negedge clk);
    low_line = 1'b0;
    @(negedge clk);
    ticks(HOLD - 1);
    chk_rst("R6 count restarted", 1'b0, 1'b0);
    final_tick(1'b0);
    chk_rst("R6 release after full hold", 1'b1, 1'b1);
    ce_in_n = '1;
  endtask

  task automatic t_battery;  // R1 R5
    ce_in_n = 2'b00;
    batt_mode = 1'b1;
    #1 chk("R5 ce forced by batt_mode", ce_out_n, 2'b11);
    @(negedge clk);
    chk_rst("R1 batt_mode asserts reset", 1'b0, 1'b0);
    batt_mode = 1'b0;
    #1 chk("R5 ce follows after batt", ce_out_n, 2'b00);
    @(negedge clk);
    ticks(HOLD - 1);
    chk_rst("R2 still held", 1'b0, 1'b0);
    final_tick(1'b0);
    chk_rst("R2 release after batt", 1'b1, 1'b1);
    ce_in_n = '1;
  endtask

  task automatic t_watchdog;  // R3 R8 R7
    @(negedge clk);
    wd_expire = 1'b1;
    @(negedge clk);
    wd_expire = 1'b0;
    chk_rst("R3 watchdog pulse starts", 1'b0, 1'b0);
    ticks(200);
    wd_expire = 1'b1;
    @(negedge clk);
    wd_expire = 1'b0;
    ticks(HOLD - 1 - 200);
    chk_rst("R8 no early release", 1'b0, 1'b0);
    final_tick(1'b0);
    chk_rst("R8 pulse not extended", 1'b1, 1'b1);
  endtask

  task automatic t_same_cycle;  // R10 and watchdog on release edge
    @(negedge clk);
    wd_expire = 1'b1;
    @(negedge clk);
    wd_expire = 1'b0;
    ticks(HOLD - 1);
    tick_en  = 1'b1;
    low_line = 1'b1;
    @(negedge clk);
    tick_en  = 1'b0;
    chk_rst("R10 fault beats final tick", 1'b0, 1'b0);
    low_line = 1'b0;
    @(negedge clk);
    ticks(HOLD - 1);
    final_tick(1'b1);
    chk_rst("R8 wd on release edge ignored", 1'b1, 1'b1);
    @(negedge clk);
    chk_rst("R8 stays released", 1'b1, 1'b0);
  endtask

  task automatic t_srst_mid;  // R9
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    chk_rst("R9 srst asserts reset", 1'b0, 1'b0);
    ticks(HOLD - 1);
    chk_rst("R9 counter was cleared", 1'b0, 1'b0);
    final_tick(1'b0);
    chk_rst("R9 release after srst", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_power_on();
    t_low_line();
    t_battery();
    t_watchdog();
    t_same_cycle();
    t_srst_mid();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule